// File: doc/BRIEF.md
# Maskable Interrupt Aggregator

This block gathers eight interrupt request strobes into one interrupt line for a host processor. Every source has its own enable bit in a mask register. When an enabled source strobes, its bit in a status vector is latched and the interrupt line rises. The line stays high until the host clears the status. The host reads the status vector to find out which sources fired.

One source position is treated differently. Its strobe is a periodic tick, so it is never latched. While its mask bit is set, it appears on the interrupt line only for the cycles in which it is asserted. A one-bit control register selects how the status vector is cleared. In one mode a read of the status clears it. In the other mode only an explicit write of 0x00 clears it. Address decoding is done outside the block: the host side drives separate write strobes for the mask, control and status registers, one shared write-data byte, and a status read strobe.

Top module: `irq_aggregator`

## Requirements
- R1: During and after synchronous active-low reset, the status vector is 0x00, the mask is 0x00 (all sources disabled), the clear mode is write-zero, and `irq_o` is 0.
- R2: A cycle with `mask_wr_i` high loads `wr_data_i` into the mask, and `mask_o` shows the new value from the next cycle on.
- R3: A strobe on a latched source (any bit except bit 5) whose mask bit is 1 sets that status bit in the next cycle, and `irq_o` is then 1.
- R4: A strobe on a source whose mask bit is 0 leaves its status bit at 0 and does not raise `irq_o`.
- R5: Once a status bit is set, `irq_o` stays 1 in every later cycle until that bit is cleared or its mask bit is turned off, even after the strobe has gone.
- R6: Source bit 5 is never latched, so `status_o[5]` is always 0. `irq_o` is 1 in exactly the cycles where `req_i[5]` is 1 and mask bit 5 is 1 (when no latched status is pending).
- R7: Control bit 0 = 0 selects write-zero mode. In this mode a status write of 0x00 clears every status bit in the next cycle. A status write of any other value, and any status read, leave the status unchanged.
- R8: Control bit 0 = 1 selects clear-on-read mode. In the cycle `stat_rd_i` is high, `status_o` still shows the pending bits, and from the next cycle it is 0x00. In this mode status writes have no effect.
- R9: An enabled request that arrives in the same cycle as a clear (by read or by write) is kept, and its status bit is 1 in the next cycle.
- R10: A mask bit gates the output of a status bit that is already latched. Clearing the mask bit drops `irq_o` but keeps the status bit, and setting the mask bit again raises `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 8 | Interrupt request strobes, one per source |
| mask_wr_i | input | 1 | Write strobe for the mask register |
| ctrl_wr_i | input | 1 | Write strobe for the control register (bit 0 = clear mode) |
| stat_wr_i | input | 1 | Write strobe for the status vector |
| stat_rd_i | input | 1 | Status read strobe |
| wr_data_i | input | 8 | Shared write data |
| status_o | output | 8 | Status vector read data |
| mask_o | output | 8 | Mask register read data |
| irq_o | output | 1 | Combined interrupt line |

## Verification
A status bit that is wrongly set or wrongly lost shows on `status_o` one cycle after the strobe or the clear that caused it. Because `irq_o` follows the status through the mask, a wrong bit also shows on `irq_o`, unless the mask hides it. A clear mode that is stuck at the wrong value shows on the first read or zero-write: the status either survives a read or vanishes after one. A fault on the pass-through source, or in the gating of the line by the mask, shows on `irq_o` in the same cycle as the strobe or the mask write.

// File: rtl/irq_agg_pkg.sv
// Package irq_agg_pkg
// Shared types and defaults for the interrupt aggregator.
// Assumes nothing beyond its own constants.
package irq_agg_pkg;

    // Default source count and position of the periodic tick source
    localparam int unsigned IRQ_NSRC_DEF  = 8;
    localparam int unsigned IRQ_PULSE_DEF = 5;

    // Status clearing discipline, held in control bit 0
    typedef enum logic {
        CLR_BY_ZERO_WRITE = 1'b0,
        CLR_ON_READ       = 1'b1
    } clr_mode_e;

endpackage

// File: rtl/irq_agg_cfg.sv
// Module irq_agg_cfg
// Holds the per-source enable mask and the clear-mode control bit.
// Assumes that each write strobe lasts one cycle and that the write
// data is valid in that cycle. Only bit 0 of the data matters for
// control writes.
module irq_agg_cfg
    import irq_agg_pkg::*;
#(
    parameter int unsigned N = IRQ_NSRC_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mask_wr,
    input  logic         ctrl_wr,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] mask,
    output clr_mode_e    mode
);

    // Only bit 0 of the data goes into the control register
    logic unused_ctrl_bits;
    assign unused_ctrl_bits = ^wdata[N-1:1];

    // Mask register: reset to all sources disabled, loaded on mask write
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask <= '0;
        else if (mask_wr)
            mask <= wdata;
    end

    // Clear-mode bit: reset to write-zero clearing, loaded from data bit 0
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= CLR_BY_ZERO_WRITE;
        else if (ctrl_wr)
            mode <= clr_mode_e'(wdata[0]);
    end

endmodule

// File: rtl/irq_clear_ctl.sv
// Module irq_clear_ctl
// Decides in which cycle the status vector is wiped. The decision
// depends on the clear mode: a status read in clear-on-read mode, or a
// status write of all zeros in write-zero mode.
// Assumes that the read and write strobes each last one cycle.
module irq_clear_ctl
    import irq_agg_pkg::*;
#(
    parameter int unsigned N = IRQ_NSRC_DEF
) (
    input  clr_mode_e    mode,
    input  logic         stat_rd,
    input  logic         stat_wr,
    input  logic [N-1:0] wdata,
    output logic         clr_all
);

    logic zero_write;

    // Recognise a write whose data is all zeros
    always_comb begin
        zero_write = stat_wr && (wdata == '0);
    end

    // Select the clearing event that the current mode honours
    always_comb begin
        unique case (mode)
            CLR_ON_READ:       clr_all = stat_rd;
            CLR_BY_ZERO_WRITE: clr_all = zero_write;
            default:           clr_all = 1'b0;
        endcase
    end

endmodule

// File: rtl/irq_src_slice.sv
// Module irq_src_slice
// Handles one interrupt source. In the latched form, an enabled strobe
// sets a sticky pending bit. The pending bit is dropped on a clear, but
// a strobe in the same cycle wins over the clear. In the pass-through
// form, nothing is stored and the enabled strobe drives the line
// directly.
// Assumes that the enable comes from a register (no combinational path
// back).
module irq_src_slice #(
    parameter bit PULSED = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic en,
    input  logic clr,
    output logic pend,
    output logic drive
);

    generate
        if (PULSED) begin : g_pass
            logic unused_pass;
            assign unused_pass = clk ^ rst_n ^ clr;

            // Periodic tick: never latched, gated by its enable only
            always_comb begin
                pend  = 1'b0;
                drive = req & en;
            end
        end else begin : g_latch
            logic pend_q;

            // Sticky pending bit: set wins over clear so no event is lost
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pend_q <= 1'b0;
                else
                    pend_q <= (pend_q & ~clr) | (req & en);
            end

            // Report the bit and drive the line while it is enabled
            always_comb begin
                pend  = pend_q;
                drive = pend_q & en;
            end
        end
    endgenerate

endmodule

// File: rtl/irq_aggregator.sv
// Module irq_aggregator
// Top level of the maskable interrupt aggregator. One slice per source
// latches or passes its request. A config block holds the mask and the
// clear mode, and a clear controller wipes the status vector. The
// contributions of all sources are ORed into one line.
// Assumes that register strobes come from an outside address decoder,
// one cycle each.
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int unsigned N         = IRQ_NSRC_DEF,
    parameter int unsigned PULSE_IDX = IRQ_PULSE_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic         mask_wr_i,
    input  logic         ctrl_wr_i,
    input  logic         stat_wr_i,
    input  logic         stat_rd_i,
    input  logic [N-1:0] wr_data_i,
    output logic [N-1:0] status_o,
    output logic [N-1:0] mask_o,
    output logic         irq_o
);

    clr_mode_e    mode_q;
    logic         clr_all;
    logic [N-1:0] pend_vec;
    logic [N-1:0] drive_vec;
    logic         rd_clears;

    irq_agg_cfg #(.N(N)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_wr (mask_wr_i),
        .ctrl_wr (ctrl_wr_i),
        .wdata   (wr_data_i),
        .mask    (mask_o),
        .mode    (mode_q)
    );

    irq_clear_ctl #(.N(N)) u_clr (
        .mode    (mode_q),
        .stat_rd (stat_rd_i),
        .stat_wr (stat_wr_i),
        .wdata   (wr_data_i),
        .clr_all (clr_all)
    );

    generate
        for (genvar i = 0; i < N; i++) begin : g_src
            irq_src_slice #(.PULSED(i == PULSE_IDX)) u_slice (
                .clk   (clk),
                .rst_n (rst_n),
                .req   (req_i[i]),
                .en    (mask_o[i]),
                .clr   (clr_all),
                .pend  (pend_vec[i]),
                .drive (drive_vec[i])
            );
        end
    endgenerate

    // Present the status and merge all source contributions onto the line
    always_comb begin
        status_o  = pend_vec;
        irq_o     = |drive_vec;
        rd_clears = (mode_q == CLR_ON_READ);
    end

endmodule

// File: rtl/irq_aggregator_chk.sv
// Module irq_aggregator_chk
// Property checker for irq_aggregator, attached with bind. It observes
// the ports and the clear-mode bit.
// Assumes a synchronous active-low reset.
module irq_aggregator_chk #(
    parameter int unsigned N    = 8,
    parameter int unsigned PIDX = 5
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] req_i,
    input logic         stat_wr_i,
    input logic         stat_rd_i,
    input logic         mask_wr_i,
    input logic [N-1:0] status_o,
    input logic [N-1:0] mask_o,
    input logic         irq_o,
    input logic         rd_clears
);

    localparam logic [N-1:0] LMASK = ~(N'(1) << PIDX);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (status_o == '0 && mask_o == '0 && !irq_o));

    // R3
    latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_i & mask_o & LMASK) != '0) |=>
        ((status_o & $past(req_i & mask_o & LMASK)) == $past(req_i & mask_o & LMASK)) && irq_o);

    // R4
    masked_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & ~$past(status_o) & ~$past(req_i & mask_o)) == '0));

    // R5
    hold_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_o & mask_o) != '0 && !stat_wr_i && !stat_rd_i && !mask_wr_i) |=> irq_o);

    // R6
    pulse_nolatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[PIDX]);

    // R6
    pulse_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i[PIDX] && mask_o[PIDX]) |-> irq_o);

    // R7
    read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_clears && stat_rd_i && !stat_wr_i) |=> (($past(status_o) & ~status_o) == '0));

    // R8
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clears && stat_rd_i && req_i == '0) |=> (status_o == '0));

    // R9
    clear_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clears && stat_rd_i) |=>
        ((status_o & $past(req_i & mask_o & LMASK)) == $past(req_i & mask_o & LMASK)));

endmodule

bind irq_aggregator irq_aggregator_chk #(.N(N), .PIDX(PULSE_IDX)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .stat_wr_i (stat_wr_i),
    .stat_rd_i (stat_rd_i),
    .mask_wr_i (mask_wr_i),
    .status_o  (status_o),
    .mask_o    (mask_o),
    .irq_o     (irq_o),
    .rd_clears (rd_clears)
);

// File: tb/sim_irq_aggregator.sv
// Directed bench for irq_aggregator. Inputs change on the falling edge
// and outputs are sampled away from the rising edge.
module sim_irq_aggregator;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_i = '0;
    logic       mask_wr_i = 1'b0;
    logic       ctrl_wr_i = 1'b0;
    logic       stat_wr_i = 1'b0;
    logic       stat_rd_i = 1'b0;
    logic [7:0] wr_data_i = '0;
    logic [7:0] status_o;
    logic [7:0] mask_o;
    logic       irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    irq_aggregator u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .mask_wr_i (mask_wr_i),
        .ctrl_wr_i (ctrl_wr_i),
        .stat_wr_i (stat_wr_i),
        .stat_rd_i (stat_rd_i),
        .wr_data_i (wr_data_i),
        .status_o  (status_o),
        .mask_o    (mask_o),
        .irq_o     (irq_o)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr_mask(logic [7:0] d);
        mask_wr_i = 1'b1; wr_data_i = d; step();
        mask_wr_i = 1'b0; wr_data_i = '0;
    endtask

    task automatic wr_ctrl(logic [7:0] d);
        ctrl_wr_i = 1'b1; wr_data_i = d; step();
        ctrl_wr_i = 1'b0; wr_data_i = '0;
    endtask

    task automatic wr_stat(logic [7:0] d);
        stat_wr_i = 1'b1; wr_data_i = d; step();
        stat_wr_i = 1'b0; wr_data_i = '0;
    endtask

    task automatic pulse_req(logic [7:0] r);
        req_i = r; step();
        req_i = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; step(); step();
        rst_n = 1'b1; step();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 status", status_o, 8'h00);
        chk("R1 mask", mask_o, 8'h00);
        chk("R1 irq", {7'd0, irq_o}, 8'h00);
    endtask

    task automatic t_mask_write();
        wr_mask(8'hFF);
        chk("R2 mask ff", mask_o, 8'hFF);
        wr_mask(8'hA5);
        chk("R2 mask a5", mask_o, 8'hA5);
    endtask

    task automatic t_masked();
        do_reset();
        wr_mask(8'hF0);
        pulse_req(8'h0F);
        chk("R4 status", status_o, 8'h00);
        chk("R4 irq", {7'd0, irq_o}, 8'h00);
    endtask

    task automatic t_latch();
        do_reset();
        wr_mask(8'hFF);
        pulse_req(8'h04);
        chk("R3 status", status_o, 8'h04);
        chk("R3 irq", {7'd0, irq_o}, 8'h01);
        repeat (5) step();
        chk("R5 status held", status_o, 8'h04);
        chk("R5 irq held", {7'd0, irq_o}, 8'h01);
    endtask

    task automatic t_clear_write();
        do_reset();
        wr_mask(8'hFF);
        pulse_req(8'h42);
        stat_rd_i = 1'b1; step(); stat_rd_i = 1'b0;
        chk("R7 read ignored", status_o, 8'h42);
        wr_stat(8'h11);
        chk("R7 nonzero write ignored", status_o, 8'h42);
        wr_stat(8'h00);
        chk("R7 zero write clears", status_o, 8'h00);
        chk("R7 irq low", {7'd0, irq_o}, 8'h00);
    endtask

    task automatic t_pulse();
        do_reset();
        wr_mask(8'hFF);
        req_i = 8'h20; #5;
        chk("R6 irq during tick", {7'd0, irq_o}, 8'h01);
        step(); req_i = '0; #5;
        chk("R6 status not latched", status_o, 8'h00);
        chk("R6 irq after tick", {7'd0, irq_o}, 8'h00);
        step();
        wr_mask(8'hDF);
        req_i = 8'h20; #5;
        chk("R6 masked tick", {7'd0, irq_o}, 8'h00);
        step(); req_i = '0;
    endtask

    task automatic t_clear_read();
        do_reset();
        wr_mask(8'hFF);
        wr_ctrl(8'h01);
        pulse_req(8'h81);
        wr_stat(8'h00);
        chk("R8 write ignored", status_o, 8'h81);
        stat_rd_i = 1'b1; #5;
        chk("R8 read data", status_o, 8'h81);
        step(); stat_rd_i = 1'b0;
        chk("R8 cleared after read", status_o, 8'h00);
        chk("R8 irq low", {7'd0, irq_o}, 8'h00);
    endtask

    task automatic t_collide();
        do_reset();
        wr_mask(8'hFF);
        wr_ctrl(8'h01);
        pulse_req(8'h01);
        stat_rd_i = 1'b1; req_i = 8'h02; step();
        stat_rd_i = 1'b0; req_i = '0;
        chk("R9 read collide", status_o, 8'h02);
        wr_ctrl(8'h00);
        stat_wr_i = 1'b1; wr_data_i = 8'h00; req_i = 8'h40; step();
        stat_wr_i = 1'b0; req_i = '0;
        chk("R9 write collide", status_o, 8'h40);
    endtask

    task automatic t_mask_gate();
        do_reset();
        wr_mask(8'hFF);
        pulse_req(8'h08);
        wr_mask(8'h00);
        chk("R10 irq gated", {7'd0, irq_o}, 8'h00);
        chk("R10 status kept", status_o, 8'h08);
        wr_mask(8'h08);
        chk("R10 irq back", {7'd0, irq_o}, 8'h01);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        step();
        t_reset();
        t_mask_write();
        t_masked();
        t_latch();
        t_clear_write();
        t_pulse();
        t_clear_read();
        t_collide();
        t_mask_gate();
        finish_run();
    end

    initial begin
        #(20 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule